// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block sits beside a processor core and observes every bus access the core makes: the address, the data value, the kind of access (instruction fetch, data read or data write) and the access size. It holds a small bank of comparator sets. A debugger loads these sets through a simple register write port, which stands in for the debug access path. When any enabled set matches the current access, the block raises a breakpoint.

One mode bit decides what a breakpoint does. In halt mode the block drives a level halt request that keeps the core in debug state. The core stays there until the debugger asks for a restart or a single step. A single step lets exactly one instruction retire, and then the core is halted again. In monitor mode the core keeps running. The block sends a one-cycle exception request that vectors the core into a resident debug monitor, so interrupt handlers can go on running. This request is held back while the core reports that it is already inside the monitor handler. A sticky status vector records which comparator sets have fired.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, halt_req, mon_exc and hit_status are all 0. Every comparator register resets to 0, so every set is disabled and the mode is halt mode.
- R2: Set c uses configuration offsets c*8+0 (reference address), +1 (address mask), +2 (reference data), +3 (data mask) and +4 (control). An address bit whose mask bit is 1 always compares equal, and any unmasked difference prevents a match.
- R3: Control word layout: bit0 enable, bits[2:1] access kind (00 fetch, 01 read, 10 write), bit3 kind don't-care, bits[5:4] size (00 byte, 01 half, 10 word), bit6 size don't-care. A kind or size that differs from the programmed one prevents a match unless the matching don't-care bit is set.
- R4: When control bit7 is set, a match also needs bus_data to equal the reference data on every bit whose data-mask bit is 0. This allows a breakpoint on one specific value written to one specific address.
- R5: A set whose enable bit is 0 never matches, and no set matches while bus_valid is 0.
- R6: Bit c of hit_status becomes 1 in the cycle after set c matches and then holds. Writing configuration offset NUM_CMP*8+1 clears every bit that has a 1 in the written data. A match in the same cycle as the clear wins.
- R7: Offset NUM_CMP*8 bit0 selects the mode (0 halt, 1 monitor). In halt mode, a match while running sets halt_req in the next cycle. halt_req holds until dbg_restart is seen, and it is low in the cycle after that.
- R8: While halted, dbg_step drops halt_req in the next cycle. halt_req returns high in the cycle after the first core_retire pulse. Matches during the step are ignored.
- R9: In monitor mode, a match while running gives a one-cycle mon_exc pulse in the next cycle, and halt_req stays low.
- R10: No mon_exc pulse follows a match that occurs while in_monitor is high.
- R11: mon_exc is never high in two consecutive cycles. A match in the cycle where mon_exc is high produces no further pulse.
- R12: The set outputs are OR-combined, so a match on any single set triggers the configured action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Core bus access present this cycle |
| bus_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Access data value |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | CFG_AW | Configuration register offset |
| cfg_wdata | input | CFG_DW | Configuration write data |
| in_monitor | input | 1 | Core is executing the monitor handler |
| dbg_restart | input | 1 | Debugger request to leave debug state |
| dbg_step | input | 1 | Debugger request to step one instruction |
| core_retire | input | 1 | Core retired one instruction |
| halt_req | output | 1 | Level request holding the core in debug state |
| mon_exc | output | 1 | One-cycle exception request to the monitor |
| hit_status | output | NUM_CMP | Sticky per-set match record |

## Verification
The bench builds the block with its default parameters: two comparator sets, 32-bit address and data, a 5-bit configuration offset and 32-bit configuration data. With two sets, one set can serve as an instruction-address breakpoint and the other as a write-value watchpoint. This makes the OR-combination, the per-set sticky bits and the case where a clear and a match land in the same cycle all reachable. It also walks the halt, step, restart and monitor paths, including back-to-back matches and matches made inside the handler.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // Access kind as driven on the observed bus
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10
  } acc_kind_e;

  // Control word of one comparator set (bit7 .. bit0)
  typedef struct packed {
    logic       use_data;   // bit7
    logic       size_any;   // bit6
    logic [1:0] size;       // bits 5:4
    logic       kind_any;   // bit3
    logic [1:0] kind;       // bits 2:1
    logic       enable;     // bit0
  } cmp_ctrl_t;

  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_HALTED = 2'b01,
    ST_STEP   = 2'b10
  } run_state_e;

  localparam int REGS_PER_CMP = 8;
  localparam int OFF_ADDR     = 0;
  localparam int OFF_AMASK    = 1;
  localparam int OFF_DATA     = 2;
  localparam int OFF_DMASK    = 3;
  localparam int OFF_CTRL     = 4;
  localparam int CTRL_W       = $bits(cmp_ctrl_t);

endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CFG_AW  = 5,
  parameter int CFG_DW  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [CFG_DW-1:0]                cfg_wdata,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]   cmp_addr_o,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]   cmp_amask_o,
  output logic [NUM_CMP-1:0][DATA_W-1:0]   cmp_data_o,
  output logic [NUM_CMP-1:0][DATA_W-1:0]   cmp_dmask_o,
  output cmp_ctrl_t [NUM_CMP-1:0]          cmp_ctrl_o,
  output logic                             mode_mon_o,
  output logic [NUM_CMP-1:0]               clr_mask_o
);

  localparam int MODE_OFF = NUM_CMP * REGS_PER_CMP;
  localparam int CLR_OFF  = MODE_OFF + 1;

  // Write strobe for one configuration offset
  function automatic logic wr_hit(input logic we, input logic [CFG_AW-1:0] a,
                                  input int off);
    return we && (a == CFG_AW'(off));
  endfunction

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_set
    localparam int BASE = c * REGS_PER_CMP;
    logic [ADDR_W-1:0] addr_q, amask_q;
    logic [DATA_W-1:0] data_q, dmask_q;
    cmp_ctrl_t         ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q  <= '0;
        amask_q <= '0;
        data_q  <= '0;
        dmask_q <= '0;
        ctrl_q  <= '0;
      end else begin
        if (wr_hit(cfg_we, cfg_addr, BASE + OFF_ADDR))  addr_q  <= cfg_wdata[ADDR_W-1:0];
        if (wr_hit(cfg_we, cfg_addr, BASE + OFF_AMASK)) amask_q <= cfg_wdata[ADDR_W-1:0];
        if (wr_hit(cfg_we, cfg_addr, BASE + OFF_DATA))  data_q  <= cfg_wdata[DATA_W-1:0];
        if (wr_hit(cfg_we, cfg_addr, BASE + OFF_DMASK)) dmask_q <= cfg_wdata[DATA_W-1:0];
        if (wr_hit(cfg_we, cfg_addr, BASE + OFF_CTRL))  ctrl_q  <= cmp_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
    end

    assign cmp_addr_o[c]  = addr_q;
    assign cmp_amask_o[c] = amask_q;
    assign cmp_data_o[c]  = data_q;
    assign cmp_dmask_o[c] = dmask_q;
    assign cmp_ctrl_o[c]  = ctrl_q;
    assign clr_mask_o[c]  = wr_hit(cfg_we, cfg_addr, CLR_OFF) && cfg_wdata[c];
  end

  logic mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mode_q <= 1'b0;
    else if (wr_hit(cfg_we, cfg_addr, MODE_OFF)) mode_q <= cfg_wdata[0];
  end
  assign mode_mon_o = mode_q;

endmodule

// File: rtl/bkpt_comparator.sv
module bkpt_comparator
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  cmp_ctrl_t          ctrl,
  input  logic [ADDR_W-1:0]  ref_addr,
  input  logic [ADDR_W-1:0]  addr_mask,
  input  logic [DATA_W-1:0]  ref_data,
  input  logic [DATA_W-1:0]  data_mask,
  input  logic               bus_valid,
  input  logic [1:0]         bus_kind,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_data,
  output logic               hit
);

  // A mask bit of 1 turns that bit position into don't-care
  function automatic logic addr_equal(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b,
                                      input logic [ADDR_W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  function automatic logic data_equal(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                      input logic [DATA_W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  function automatic logic field_ok(input logic any, input logic [1:0] want, input logic [1:0] got);
    return any || (want == got);
  endfunction

  logic addr_ok, kind_ok, size_ok, data_ok;

  assign addr_ok = addr_equal(bus_addr, ref_addr, addr_mask);
  assign kind_ok = field_ok(ctrl.kind_any, ctrl.kind, bus_kind);
  assign size_ok = field_ok(ctrl.size_any, ctrl.size, bus_size);
  assign data_ok = !ctrl.use_data || data_equal(bus_data, ref_data, data_mask);
  assign hit     = ctrl.enable && bus_valid && addr_ok && kind_ok && size_ok && data_ok;

endmodule

// File: rtl/bkpt_run_ctrl.sv
module bkpt_run_ctrl
  import bkpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_hit,
  input  logic mode_mon,
  input  logic in_monitor,
  input  logic dbg_restart,
  input  logic dbg_step,
  input  logic core_retire,
  output logic halt_req,
  output logic mon_exc,
  output logic step_active
);

  run_state_e state_q, state_d;
  logic       exc_q, exc_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (any_hit && !mode_mon) state_d = ST_HALTED;
      ST_HALTED: if (dbg_restart)          state_d = ST_RUN;
                 else if (dbg_step)        state_d = ST_STEP;
      ST_STEP:   if (core_retire)          state_d = ST_HALTED;
      default:                             state_d = ST_RUN;
    endcase
  end

  // Pulse only while running, never inside the handler, never twice in a row
  assign exc_d = any_hit && mode_mon && !in_monitor && !exc_q && (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      exc_q   <= exc_d;
    end
  end

  assign halt_req    = (state_q == ST_HALTED);
  assign step_active = (state_q == ST_STEP);
  assign mon_exc     = exc_q;

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CFG_AW  = $clog2(NUM_CMP * 8 + 2),
  parameter int CFG_DW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic [1:0]         bus_kind,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               in_monitor,
  input  logic               dbg_restart,
  input  logic               dbg_step,
  input  logic               core_retire,
  output logic               halt_req,
  output logic               mon_exc,
  output logic [NUM_CMP-1:0] hit_status
);

  logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_addr, cmp_amask;
  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_data, cmp_dmask;
  cmp_ctrl_t [NUM_CMP-1:0]        cmp_ctrl;
  logic                           mode_mon;
  logic [NUM_CMP-1:0]             clr_mask;
  logic [NUM_CMP-1:0]             cmp_hit;
  logic                           any_hit;
  logic                           step_active;

  bkpt_cfg_regs #(
    .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cmp_addr_o (cmp_addr),
    .cmp_amask_o(cmp_amask),
    .cmp_data_o (cmp_data),
    .cmp_dmask_o(cmp_dmask),
    .cmp_ctrl_o (cmp_ctrl),
    .mode_mon_o (mode_mon),
    .clr_mask_o (clr_mask)
  );

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    bkpt_comparator #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmp_i (
      .ctrl     (cmp_ctrl[c]),
      .ref_addr (cmp_addr[c]),
      .addr_mask(cmp_amask[c]),
      .ref_data (cmp_data[c]),
      .data_mask(cmp_dmask[c]),
      .bus_valid(bus_valid),
      .bus_kind (bus_kind),
      .bus_size (bus_size),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .hit      (cmp_hit[c])
    );

    // Sticky record: a new match outranks a clear in the same cycle
    logic sticky_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= 1'b0;
      else        sticky_q <= cmp_hit[c] || (sticky_q && !clr_mask[c]);
    end
    assign hit_status[c] = sticky_q;
  end

  assign any_hit = |cmp_hit;

  bkpt_run_ctrl run_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_hit    (any_hit),
    .mode_mon   (mode_mon),
    .in_monitor (in_monitor),
    .dbg_restart(dbg_restart),
    .dbg_step   (dbg_step),
    .core_retire(core_retire),
    .halt_req   (halt_req),
    .mon_exc    (mon_exc),
    .step_active(step_active)
  );

endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk #(
  parameter int NUM_CMP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               any_hit,
  input logic               mode_mon,
  input logic               step_active,
  input logic               in_monitor,
  input logic               dbg_restart,
  input logic               dbg_step,
  input logic               core_retire,
  input logic               halt_req,
  input logic               mon_exc,
  input logic [NUM_CMP-1:0] hit_status
);

  assert_exc_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mon_exc |=> !mon_exc);

  assert_exc_outside_handler_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mon_exc |-> $past(!in_monitor));

  assert_exc_from_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mon_exc |-> $past(any_hit && mode_mon));

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !dbg_restart && !dbg_step) |=> halt_req);

  assert_restart_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && dbg_restart) |=> !halt_req);

  assert_step_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && dbg_step && !dbg_restart) |=> (!halt_req && step_active));

  assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> ($past(any_hit && !mode_mon) || $past(step_active && core_retire)));

  assert_sticky_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(hit_status) & ~hit_status)) |-> $past(cfg_we));

  assert_sticky_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_status & ~$past(hit_status))) |-> $past(any_hit));

endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.NUM_CMP(NUM_CMP)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .any_hit    (any_hit),
  .mode_mon   (mode_mon),
  .step_active(step_active),
  .in_monitor (in_monitor),
  .dbg_restart(dbg_restart),
  .dbg_step   (dbg_step),
  .core_retire(core_retire),
  .halt_req   (halt_req),
  .mon_exc    (mon_exc),
  .hit_status (hit_status)
);

// File: tb/bkpt_match_unit_tb_top.sv
module bkpt_match_unit_tb_top;

  localparam int NUM_CMP = 2;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int CFG_AW  = 5;
  localparam int CFG_DW  = 32;

  // Encodings restated from the requirements
  localparam logic [1:0] K_FETCH = 2'b00, K_READ = 2'b01, K_WRITE = 2'b10;
  localparam logic [1:0] S_HALF = 2'b01, S_WORD = 2'b10;
  localparam int MODE_REG = NUM_CMP * 8;
  localparam int CLR_REG  = MODE_REG + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic               bus_valid = 1'b0, cfg_we = 1'b0;
  logic [1:0]         bus_kind = '0, bus_size = '0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [DATA_W-1:0]  bus_data = '0;
  logic [CFG_AW-1:0]  cfg_addr = '0;
  logic [CFG_DW-1:0]  cfg_wdata = '0;
  logic               in_monitor = 1'b0, dbg_restart = 1'b0, dbg_step = 1'b0, core_retire = 1'b0;
  logic               halt_req, mon_exc;
  logic [NUM_CMP-1:0] hit_status;

  bkpt_match_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_data(bus_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_monitor(in_monitor), .dbg_restart(dbg_restart),
    .dbg_step(dbg_step), .core_retire(core_retire), .halt_req(halt_req), .mon_exc(mon_exc),
    .hit_status(hit_status)
  );

  // Pending stimulus for the next cycle
  logic               n_valid = 1'b0, n_we = 1'b0, n_mon = 1'b0, n_restart = 1'b0, n_step = 1'b0, n_retire = 1'b0;
  logic [1:0]         n_kind = '0, n_size = '0;
  logic [ADDR_W-1:0]  n_addr = '0;
  logic [DATA_W-1:0]  n_data = '0;
  logic [CFG_AW-1:0]  n_caddr = '0;
  logic [CFG_DW-1:0]  n_cdata = '0;

  typedef struct {
    int                 cyc;
    string              tag;
    logic               halt;
    logic               exc;
    logic [NUM_CMP-1:0] stat;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   cyc_cnt = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // Monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].cyc == cyc_cnt) begin
      cur = sb.pop_front();
      checks += 3;
      if (halt_req !== cur.halt) begin
        failures++;
        $display("FAIL %s halt_req actual=%0b expected=%0b", cur.tag, halt_req, cur.halt);
      end
      if (mon_exc !== cur.exc) begin
        failures++;
        $display("FAIL %s mon_exc actual=%0b expected=%0b", cur.tag, mon_exc, cur.exc);
      end
      if (hit_status !== cur.stat) begin
        failures++;
        $display("FAIL %s hit_status actual=%b expected=%b", cur.tag, hit_status, cur.stat);
      end
    end
  end

  // Driver: apply pending stimulus for one cycle and queue the result expected after it
  task automatic tick(input string tag, input logic eh, input logic ee, input logic [NUM_CMP-1:0] es);
    exp_t e;
    @(negedge clk);
    bus_valid = n_valid; bus_kind = n_kind; bus_size = n_size; bus_addr = n_addr; bus_data = n_data;
    cfg_we = n_we; cfg_addr = n_caddr; cfg_wdata = n_cdata;
    in_monitor = n_mon; dbg_restart = n_restart; dbg_step = n_step; core_retire = n_retire;
    e.cyc = cyc_cnt + 1; e.tag = tag; e.halt = eh; e.exc = ee; e.stat = es;
    sb.push_back(e);
    n_valid = 1'b0; n_we = 1'b0; n_restart = 1'b0; n_step = 1'b0; n_retire = 1'b0; n_mon = 1'b0;
  endtask

  task automatic cfg(input int a, input logic [CFG_DW-1:0] d);
    n_we = 1'b1; n_caddr = CFG_AW'(a); n_cdata = d;
  endtask

  task automatic acc(input logic [1:0] k, input logic [1:0] s, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d);
    n_valid = 1'b1; n_kind = k; n_size = s; n_addr = a; n_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R1 reset state", 0, 0, 2'b00);
    acc(K_FETCH, S_WORD, 32'h0, 32'h0);
    tick("R1 R5 reset sets disabled", 0, 0, 2'b00);

    // set0: fetch breakpoint at 0x100, any size
    cfg(0, 32'h100);            tick("cfg", 0, 0, 2'b00);
    cfg(4, 32'h41);             tick("cfg", 0, 0, 2'b00);
    acc(K_FETCH, S_WORD, 32'h104, 0);
    tick("R2 unmasked address differs", 0, 0, 2'b00);
    acc(K_READ, S_WORD, 32'h100, 0);
    tick("R3 kind mismatch", 0, 0, 2'b00);
    acc(K_FETCH, S_WORD, 32'h100, 0);
    tick("R7 fetch hit halts", 1, 0, 2'b01);
    tick("R7 halt holds", 1, 0, 2'b01);
    acc(K_FETCH, S_WORD, 32'h100, 0);
    tick("R7 halt holds under hit", 1, 0, 2'b01);
    n_step = 1'b1;              tick("R8 step releases", 0, 0, 2'b01);
    acc(K_FETCH, S_WORD, 32'h100, 0);
    tick("R8 waiting for retire", 0, 0, 2'b01);
    n_retire = 1'b1;            tick("R8 retire re-halts", 1, 0, 2'b01);
    n_restart = 1'b1;           tick("R7 restart", 0, 0, 2'b01);
    tick("R7 running", 0, 0, 2'b01);
    cfg(CLR_REG, 32'h1);        tick("R6 clear", 0, 0, 2'b00);

    // Address mask
    cfg(1, 32'hF);              tick("cfg", 0, 0, 2'b00);
    acc(K_FETCH, S_HALF, 32'h10C, 0);
    tick("R2 masked bits ignored", 1, 0, 2'b01);
    n_restart = 1'b1;           tick("R7 restart", 0, 0, 2'b01);

    // set1: write of 0xCAFE to 0x200, word size, monitor mode
    cfg(8, 32'h200);            tick("cfg", 0, 0, 2'b01);
    cfg(10, 32'hCAFE);          tick("cfg", 0, 0, 2'b01);
    cfg(12, 32'hA5);            tick("cfg", 0, 0, 2'b01);
    cfg(MODE_REG, 32'h1);       tick("cfg", 0, 0, 2'b01);
    acc(K_WRITE, S_WORD, 32'h200, 32'hBEEF);
    tick("R4 data mismatch", 0, 0, 2'b01);
    acc(K_WRITE, S_HALF, 32'h200, 32'hCAFE);
    tick("R3 size mismatch", 0, 0, 2'b01);
    acc(K_WRITE, S_WORD, 32'h200, 32'hCAFE);
    tick("R4 R9 R12 data hit pulses", 0, 1, 2'b11);
    tick("R9 pulse one cycle", 0, 0, 2'b11);
    acc(K_WRITE, S_WORD, 32'h200, 32'hCAFE);
    tick("R11 first of pair", 0, 1, 2'b11);
    acc(K_WRITE, S_WORD, 32'h200, 32'hCAFE);
    tick("R11 second suppressed", 0, 0, 2'b11);
    acc(K_WRITE, S_WORD, 32'h200, 32'hCAFE); n_mon = 1'b1;
    tick("R10 inside handler", 0, 0, 2'b11);
    acc(K_WRITE, S_WORD, 32'h200, 32'hCAFE); n_mon = 1'b1; cfg(CLR_REG, 32'h3);
    tick("R6 set wins over clear", 0, 0, 2'b10);
    cfg(12, 32'h0);             tick("cfg", 0, 0, 2'b10);
    acc(K_WRITE, S_WORD, 32'h200, 32'hCAFE);
    tick("R5 disabled set silent", 0, 0, 2'b10);

    // set0 with kind don't-care
    cfg(4, 32'h49);             tick("cfg", 0, 0, 2'b10);
    acc(K_READ, S_WORD, 32'h100, 0); n_valid = 1'b0;
    tick("R5 invalid access ignored", 0, 0, 2'b10);
    acc(K_READ, S_WORD, 32'h100, 0);
    tick("R3 R12 kind any hits", 0, 1, 2'b11);
    tick("R9 idle after pulse", 0, 0, 2'b11);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard left=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule